// File: doc/BRIEF.md
# GPIO Port Configuration Register File

This block holds the per-pin configuration of one GPIO port of up to 32 pins and turns it into pad-side controls. Four configuration bits per pin decide the pin's role: an interrupt-select bit, a GPIO-select bit and two pattern bits. The meaning of the pattern bits depends on the role. In GPIO mode they give the direction and the output value. In device-function mode they give a 2-bit function number for the pad mux. In interrupt mode they hold trigger settings for a detector outside this block. A fifth per-pin register disables the pin's pull resistor. A disabled pull can only be re-enabled on pins built with a pull-up or pull-down.

Software reaches each register through three word offsets. The value offset reads the register and overwrites it on a write. The set offset ORs the written word into the register. The clear offset removes the written ones from the register. So one pin can be changed without a read-modify-write. A read-only level register returns the pad inputs after a synchronizer.

Top module: `gpio_cfg_regfile`

## Requirements
- R1: After reset, every pin is a GPIO input: interrupt-select 0, GPIO-select all ones, pattern-1 all ones, pattern-0 0, pull-disable all ones. Output-enable, output value, function enable and pull enable are all zero.
- R2: A write to a set offset (0x014, 0x024, 0x034, 0x044, 0x084) sets the register bits where the word is 1. A write to a clear offset (0x018, 0x028, 0x038, 0x048, 0x088) clears them. Zero bits of the word leave the register unchanged.
- R3: With interrupt-select 0 and GPIO-select 1, the pin is GPIO. Output-enable is asserted when pattern-1 is 0, and the output value follows pattern-0.
- R4: With interrupt-select 0 and GPIO-select 0, the pin is a device function. Its function enable is 1, and its 2-bit select is pattern-1 × 2 + pattern-0 (bits 2i+1:2i for pin i). Output-enable and output value are 0.
- R5: With interrupt-select 1, output-enable, output value, function enable and function select are all 0 for that pin.
- R6: Offset 0x000 reads the pad inputs through a two-flop synchronizer. A pad change is visible to a read issued two clock edges after the change, and not to a read issued one edge after it. Writes to 0x000 have no effect.
- R7: Pull enable is the inverse of the pull-disable bit. Clearing that bit, either through the clear offset or by writing a zero at the value offset, takes effect only on pins whose pull-up or pull-down capability bit is set. Setting it takes effect on every pin.
- R8: Read data appears on the cycle after the read strobe. Reads of set or clear offsets, reads of unmapped offsets, and read bits at or above the pin count all return zero.
- R9: The value offsets 0x010 (interrupt-select), 0x020 (GPIO-select), 0x030 (pattern-1), 0x040 (pattern-0) and 0x080 (pull-disable) write the whole register and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after rd_en_i |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe_o | output | NUM_PINS | Per-pin GPIO output enable |
| pad_out_o | output | NUM_PINS | Per-pin GPIO output value |
| func_en_o | output | NUM_PINS | Per-pin device-function mode |
| func_sel_o | output | 2*NUM_PINS | Per-pin device-function number |
| pull_en_o | output | NUM_PINS | Per-pin pull resistor enable |

## Verification
The bench builds the port with eight pins, pull-up capability on pins 0 to 3, pull-down capability on pins 4 and 5, and no capability on pins 6 and 7. With eight pins, a sweep of 16 rotations gives every pin all 16 combinations of its four configuration bits. Every mode's decode is therefore compared against arithmetic expectations, both at the pad controls and by read-back. The mixed capability masks let one write show that a clear reaches only the capable pins. The narrow port leaves 24 upper data bits that must read as zero.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int NUM_CFG  = 5;
  localparam int CFG_IRQ  = 0;
  localparam int CFG_GPIO = 1;
  localparam int CFG_PAT1 = 2;
  localparam int CFG_PAT0 = 3;
  localparam int CFG_PDIS = 4;

  localparam logic [11:0] OFF_LEVEL = 12'h000;
  localparam logic [11:0] OFF_SET   = 12'h004;
  localparam logic [11:0] OFF_CLR   = 12'h008;

  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_SET, OP_CLR} cfg_op_e;

  function automatic logic [11:0] cfg_base(input int k);
    case (k)
      CFG_IRQ:  return 12'h010;
      CFG_GPIO: return 12'h020;
      CFG_PAT1: return 12'h030;
      CFG_PAT0: return 12'h040;
      default:  return 12'h080;
    endcase
  endfunction

  function automatic logic cfg_rst_bit(input int k);
    return (k == CFG_GPIO) || (k == CFG_PAT1) || (k == CFG_PDIS);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_cfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_en_i,
  output cfg_op_e [NUM_CFG-1:0]      op_o,
  output logic    [NUM_CFG-1:0]      val_hit_o,
  output logic                       level_hit_o
);
  localparam logic [ADDR_W-1:0] LEVEL_A = ADDR_W'(OFF_LEVEL);

  always_comb begin
    level_hit_o = (addr_i == LEVEL_A);
    for (int k = 0; k < NUM_CFG; k++) begin
      logic hv, hs, hc;
      hv = (addr_i == ADDR_W'(cfg_base(k)));
      hs = (addr_i == ADDR_W'(cfg_base(k) + OFF_SET));
      hc = (addr_i == ADDR_W'(cfg_base(k) + OFF_CLR));
      val_hit_o[k] = hv;
      op_o[k]      = OP_NONE;
      if (wr_en_i) begin
        if (hv)      op_o[k] = OP_LOAD;
        else if (hs) op_o[k] = OP_SET;
        else if (hc) op_o[k] = OP_CLR;
      end
    end
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
  import gpio_cfg_pkg::*;
#(
  parameter int           W      = 32,
  parameter logic [W-1:0] RST    = '0,
  parameter logic [W-1:0] CLR_OK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cfg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;

  // bits outside CLR_OK can be raised but never lowered
  always_comb begin
    case (op_i)
      OP_LOAD: d = (wdata_i & CLR_OK) | (~CLR_OK & (q_o | wdata_i));
      OP_SET:  d = q_o | wdata_i;
      OP_CLR:  d = q_o & ~(wdata_i & CLR_OK);
      default: d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST;
    else         q_o <= d;
  end
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode #(
  parameter int N = 32
) (
  input  logic [N-1:0]   irq_i,
  input  logic [N-1:0]   gpio_i,
  input  logic [N-1:0]   pat1_i,
  input  logic [N-1:0]   pat0_i,
  output logic [N-1:0]   oe_o,
  output logic [N-1:0]   out_o,
  output logic [N-1:0]   fen_o,
  output logic [2*N-1:0] fsel_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic is_gpio, is_func;
    assign is_gpio         = ~irq_i[i] &  gpio_i[i];
    assign is_func         = ~irq_i[i] & ~gpio_i[i];
    assign oe_o[i]         = is_gpio & ~pat1_i[i];
    assign out_o[i]        = is_gpio &  pat0_i[i];
    assign fen_o[i]        = is_func;
    assign fsel_o[2*i+1]   = is_func & pat1_i[i];
    assign fsel_o[2*i]     = is_func & pat0_i[i];
  end
endmodule

// File: rtl/gpio_cfg_regfile.sv
module gpio_cfg_regfile
  import gpio_cfg_pkg::*;
#(
  parameter int                  NUM_PINS    = 32,
  parameter int                  ADDR_W      = 12,
  parameter int                  DATA_W      = 32,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] PULL_UP_CAP = '1,
  parameter logic [NUM_PINS-1:0] PULL_DN_CAP = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   func_en_o,
  output logic [2*NUM_PINS-1:0] func_sel_o,
  output logic [NUM_PINS-1:0]   pull_en_o
);
  localparam logic [NUM_PINS-1:0] PULL_CAP = PULL_UP_CAP | PULL_DN_CAP;

  cfg_op_e [NUM_CFG-1:0]             op;
  logic    [NUM_CFG-1:0]             val_hit;
  logic                              level_hit;
  logic    [NUM_CFG-1:0][NUM_PINS-1:0] cfg_q;
  logic    [NUM_PINS-1:0]            level;
  logic    [DATA_W-1:0]              rd_next;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .op_o        (op),
    .val_hit_o   (val_hit),
    .level_hit_o (level_hit)
  );

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    localparam logic [NUM_PINS-1:0] RST_V = {NUM_PINS{cfg_rst_bit(k)}};
    localparam logic [NUM_PINS-1:0] CLR_V = (k == CFG_PDIS) ? PULL_CAP : '1;
    gpio_setclr_reg #(.W(NUM_PINS), .RST(RST_V), .CLR_OK(CLR_V)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op[k]),
      .wdata_i (wdata_i[NUM_PINS-1:0]),
      .q_o     (cfg_q[k])
    );
  end

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (level)
  );

  gpio_pin_mode #(.N(NUM_PINS)) u_mode (
    .irq_i  (cfg_q[CFG_IRQ]),
    .gpio_i (cfg_q[CFG_GPIO]),
    .pat1_i (cfg_q[CFG_PAT1]),
    .pat0_i (cfg_q[CFG_PAT0]),
    .oe_o   (pad_oe_o),
    .out_o  (pad_out_o),
    .fen_o  (func_en_o),
    .fsel_o (func_sel_o)
  );

  assign pull_en_o = ~cfg_q[CFG_PDIS];

  always_comb begin
    rd_next = '0;
    if (level_hit) rd_next[NUM_PINS-1:0] = level;
    for (int k = 0; k < NUM_CFG; k++)
      if (val_hit[k]) rd_next[NUM_PINS-1:0] = cfg_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/gpio_cfg_checker.sv
module gpio_cfg_checker
  import gpio_cfg_pkg::*;
#(
  parameter int                  NUM_PINS    = 32,
  parameter int                  ADDR_W      = 12,
  parameter int                  DATA_W      = 32,
  parameter logic [NUM_PINS-1:0] PULL_UP_CAP = '1,
  parameter logic [NUM_PINS-1:0] PULL_DN_CAP = '0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic                  rd_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM_PINS-1:0]   pad_oe_o,
  input logic [NUM_PINS-1:0]   func_en_o,
  input logic [NUM_PINS-1:0]   pull_en_o,
  input logic [NUM_PINS-1:0]   irq_q,
  input logic [NUM_PINS-1:0]   gpio_q
);
  localparam logic [NUM_PINS-1:0] CAP = PULL_UP_CAP | PULL_DN_CAP;
  localparam logic [ADDR_W-1:0] GPIO_SET_A = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] IRQ_CLR_A  = ADDR_W'(12'h018);

  logic alias_rd;
  always_comb begin
    alias_rd = 1'b0;
    for (int k = 0; k < NUM_CFG; k++)
      if (addr_i == ADDR_W'(cfg_base(k) + OFF_SET) || addr_i == ADDR_W'(cfg_base(k) + OFF_CLR))
        alias_rd = 1'b1;
  end

  a_r2_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == GPIO_SET_A) |=>
      ((gpio_q & $past(wdata_i[NUM_PINS-1:0])) == $past(wdata_i[NUM_PINS-1:0])));

  a_r2_clr_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IRQ_CLR_A) |=> ((irq_q & $past(wdata_i[NUM_PINS-1:0])) == '0));

  a_r4_oe_not_func: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & func_en_o) == '0);

  a_r5_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q & (pad_oe_o | func_en_o)) == '0);

  a_r7_pull_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & ~CAP) == '0);

  a_r8_alias_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && alias_rd) |=> (rdata_o == '0));
endmodule

bind gpio_cfg_regfile gpio_cfg_checker #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PULL_UP_CAP(PULL_UP_CAP), .PULL_DN_CAP(PULL_DN_CAP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_oe_o  (pad_oe_o),
  .func_en_o (func_en_o),
  .pull_en_o (pull_en_o),
  .irq_q     (cfg_q[0]),
  .gpio_q    (cfg_q[1])
);

// File: tb/gpio_cfg_regfile_tb_top.sv
`timescale 1ns/1ps
module gpio_cfg_regfile_tb_top;
  localparam int N = 8;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [N-1:0] UP_CAP = 8'h0F;
  localparam logic [N-1:0] DN_CAP = 8'h30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [N-1:0] pad_in_i = '0;
  logic [N-1:0] pad_oe_o, pad_out_o, func_en_o, pull_en_o;
  logic [2*N-1:0] func_sel_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  gpio_cfg_regfile #(.NUM_PINS(N), .ADDR_W(AW), .DATA_W(DW),
    .PULL_UP_CAP(UP_CAP), .PULL_DN_CAP(DN_CAP)) dut_i (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_oe_o, .pad_out_o, .func_en_o, .func_sel_o, .pull_en_o);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    logic [DW-1:0] d;
    logic [N-1:0] wi, wm, w1, w0, e_oe, e_out, e_fen;
    logic [2*N-1:0] e_fsel;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 oe", DW'(pad_oe_o), 0);
    chk("R1 out", DW'(pad_out_o), 0);
    chk("R1 fen", DW'(func_en_o), 0);
    chk("R1 pull", DW'(pull_en_o), 0);
    rd(12'h010, d); chk("R1 irq", d, 32'h00);
    rd(12'h020, d); chk("R1 gpio", d, 32'hFF);
    rd(12'h030, d); chk("R1 pat1", d, 32'hFF);
    rd(12'h040, d); chk("R1 pat0", d, 32'h00);
    rd(12'h080, d); chk("R1 pdis", d, 32'hFF);

    // R2 set/clear with unchanged zero bits
    wr(12'h040, 32'hA5);
    wr(12'h044, 32'h0F); rd(12'h040, d); chk("R2 set", d, 32'hAF);
    wr(12'h048, 32'h81); rd(12'h040, d); chk("R2 clr", d, 32'h2E);
    wr(12'h014, 32'h00); rd(12'h010, d); chk("R2 set zero", d, 32'h00);
    wr(12'h028, 32'h00); rd(12'h020, d); chk("R2 clr zero", d, 32'hFF);

    // R3 R4 R5 R9 sweep: pin i gets config (i+k)%16 = {irq,gpio,pat1,pat0}
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = (i + k) % 16;
        wi[i] = c[3]; wm[i] = c[2]; w1[i] = c[1]; w0[i] = c[0];
        e_oe[i]  = !c[3] && c[2] && !c[1];
        e_out[i] = !c[3] && c[2] && c[0];
        e_fen[i] = !c[3] && !c[2];
        e_fsel[2*i+1] = e_fen[i] && c[1];
        e_fsel[2*i]   = e_fen[i] && c[0];
      end
      wr(12'h010, DW'(wi));
      wr(12'h020, DW'(wm));
      wr(12'h030, DW'(w1));
      wr(12'h048, 32'hFF);
      wr(12'h044, DW'(w0));
      chk("R3 oe", DW'(pad_oe_o), DW'(e_oe));
      chk("R3 out", DW'(pad_out_o), DW'(e_out));
      chk("R4 fen", DW'(func_en_o), DW'(e_fen));
      chk("R4 fsel", DW'(func_sel_o), DW'(e_fsel));
      rd(12'h010, d); chk("R9 irq", d, DW'(wi));
      rd(12'h020, d); chk("R9 gpio", d, DW'(wm));
      rd(12'h030, d); chk("R9 pat1", d, DW'(w1));
      rd(12'h040, d); chk("R9 pat0", d, DW'(w0));
    end

    // R5 all pins interrupt with every pattern
    wr(12'h014, 32'hFF);
    wr(12'h030, 32'h3C); wr(12'h040, 32'h5A);
    chk("R5 oe", DW'(pad_oe_o), 0);
    chk("R5 out", DW'(pad_out_o), 0);
    chk("R5 fen", DW'(func_en_o), 0);
    chk("R5 fsel", DW'(func_sel_o), 0);

    // R7 pull capability gating
    wr(12'h088, 32'hFF); rd(12'h080, d); chk("R7 clr cap", d, 32'hC0);
    chk("R7 pull_en", DW'(pull_en_o), 32'h3F);
    wr(12'h084, 32'h85); rd(12'h080, d); chk("R7 set", d, 32'hC5);
    wr(12'h080, 32'h00); rd(12'h080, d); chk("R7 load", d, 32'hC0);
    wr(12'h080, 32'hFF); chk("R7 all off", DW'(pull_en_o), 0);

    // R6 synchronizer latency and read-only level
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] old_v, new_v;
      old_v = pad_in_i;
      new_v = N'(8'h3C ^ (p * 8'h51));
      @(negedge clk_i); pad_in_i = new_v;
      rd(12'h000, d); chk("R6 one edge", d, DW'(old_v));
      rd(12'h000, d); chk("R6 two edges", d, DW'(new_v));
    end
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, d); chk("R6 write ignored", d, DW'(pad_in_i));

    // R8 aliases, unmapped, upper bits
    rd(12'h014, d); chk("R8 alias 14", d, 0);
    rd(12'h028, d); chk("R8 alias 28", d, 0);
    rd(12'h038, d); chk("R8 alias 38", d, 0);
    rd(12'h044, d); chk("R8 alias 44", d, 0);
    rd(12'h088, d); chk("R8 alias 88", d, 0);
    rd(12'h050, d); chk("R8 unmapped 50", d, 0);
    rd(12'h004, d); chk("R8 unmapped 04", d, 0);
    rd(12'h0F0, d); chk("R8 unmapped F0", d, 0);
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, d); chk("R8 upper zero", d, 32'hFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule